// File: doc/BRIEF.md
# DCT Result Reorder and Pass Steering

This block sits behind the arithmetic of a shared one-dimensional 8-point DCT engine. That engine computes both passes of a two-dimensional transform: rows first, then columns. The engine produces even-index results on one stream and odd-index results on another. Each result carries a one-bit tag that names the pass it belongs to. The block collects the two halves of every vector, holds them in a bank reserved for that pass, and sends them out again in natural index order, one coefficient per clock.

First-pass vectors leave on a write port that feeds the transpose storage. Each value carries its coefficient index, which the transpose storage can use as part of its address. Second-pass vectors leave on the final coefficient port. Each pass owns a bank with two vector slots, so one vector can fill while the previous one drains. The two passes run independently, so both ports can be active in the same cycle.

Top module: `dct_out_reorder`

## Requirements
- R1: While reset is high, and in the first cycle after a clock edge that sampled reset high, `tm_we` and `co_vld` are 0. Reset is synchronous and active high.
- R2: On the even stream, a pass delivers its values in the order Z0, Z2, Z4, Z6. On the odd stream, it delivers them in the order Z1, Z3, Z5, Z7. A tag of 0 marks the first pass and a tag of 1 marks the second pass.
- R3: Each first-pass vector appears on the transpose port as eight consecutive valid cycles carrying Z0 to Z7 in natural order. `tm_idx` equals k when Z(k) is presented.
- R4: Each second-pass vector appears on the final port in the same way, on `co_vld`, `co_idx` and `co_data`.
- R5: A value tagged with one pass never appears on the other pass's port.
- R6: No output of a vector begins before all eight of its values have been accepted. If the last value is sampled at clock edge E, index 0 is valid after edge E+2.
- R7: Each pass bank holds two vectors. If the next vector of a pass is complete by the time the current vector's index 7 has been read, its index 0 follows with no idle cycle between them.
- R8: The even and odd halves of a vector fill independently. Either half may arrive first, or both may arrive in the same cycles. The vector counts as complete when both halves are in.
- R9: First-pass and second-pass vectors drain concurrently, so `tm_we` and `co_vld` can both be high in one cycle.
- R10: Reset discards a partly collected vector. After reset, no output appears until a fresh complete vector has been accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_vld | input | 1 | Even-stream value valid |
| ev_pass | input | 1 | Pass tag of the even value (0 first, 1 second) |
| ev_data | input | W | Even-stream value |
| od_vld | input | 1 | Odd-stream value valid |
| od_pass | input | 1 | Pass tag of the odd value |
| od_data | input | W | Odd-stream value |
| tm_we | output | 1 | Transpose-storage write enable (first pass) |
| tm_idx | output | log2(NPT) | Coefficient index of the transpose write |
| tm_data | output | W | Transpose write data |
| co_vld | output | 1 | Final coefficient valid (second pass) |
| co_idx | output | log2(NPT) | Final coefficient index |
| co_data | output | W | Final coefficient value |

## Verification
The bench builds the block with its defaults: W=12, NPT=8 and NSLOT=2.

With these values the 3-bit index wraps from 7 to 0 between back-to-back vectors. The slot pointers of both halves also wrap many times over a run. Because there are only two slots, vectors spaced eight cycles apart are enough to make a bank's reads and writes overlap.

The stimulus places the even and odd halves at offsets 0 to 3 cycles from each other, in both orders, so the completion point falls on either half. The passes alternate and also repeat, which exercises concurrent draining on both ports as well as gap-free draining on one port.

// File: rtl/dro_pkg.sv
package dro_pkg;

  // Pass tag carried by every result coming out of the 1-D engine
  typedef enum logic {
    PASS_ROW = 1'b0,
    PASS_COL = 1'b1
  } pass_e;

  localparam int NPASS = 2;

endpackage

// File: rtl/dro_wr_seq.sv
// Write sequencer for one half-stream: position inside the half-vector
// and the slot currently being filled.
module dro_wr_seq #(
  parameter int HALF  = 4,
  parameter int NSLOT = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  output logic [$clog2(NSLOT)-1:0] slot,
  output logic [$clog2(HALF)-1:0]  cnt,
  output logic                     last
);
  localparam int SW = $clog2(NSLOT);
  localparam int HW = $clog2(HALF);

  logic at_end;
  assign at_end = (cnt == HW'(HALF - 1));
  assign last   = we && at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      slot <= '0;
    end else if (we) begin
      if (at_end) begin
        cnt  <= '0;
        slot <= (slot == SW'(NSLOT - 1)) ? '0 : slot + 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dro_bank.sv
// Reorder bank for one pass: two half memories (even / odd index),
// NSLOT vector slots each, drained in natural index order.
module dro_bank #(
  parameter int W     = 12,
  parameter int NPT   = 8,
  parameter int NSLOT = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   e_we,
  input  logic [W-1:0]           e_data,
  input  logic                   o_we,
  input  logic [W-1:0]           o_data,
  output logic                   out_vld,
  output logic [$clog2(NPT)-1:0] out_idx,
  output logic [W-1:0]           out_data
);
  localparam int HALF  = NPT / 2;
  localparam int HW    = $clog2(HALF);
  localparam int IW    = $clog2(NPT);
  localparam int SW    = $clog2(NSLOT);
  localparam int AW    = SW + HW;
  localparam int DEPTH = NSLOT * HALF;

  logic [1:0]             h_we;
  logic [1:0][W-1:0]      h_data;
  logic [1:0][SW-1:0]     h_slot;
  logic [1:0][HW-1:0]     h_cnt;
  logic [1:0]             h_last;
  logic [1:0][W-1:0]      h_rdq;
  logic [1:0][NSLOT-1:0]  done;
  logic [NSLOT-1:0]       full;

  logic          rd_act;
  logic [SW-1:0] rd_slot;
  logic [IW-1:0] rd_idx;
  logic [AW-1:0] rd_addr;
  logic          emit;
  logic          rd_end;
  logic          vld1;
  logic [IW-1:0] idx1;

  assign h_we   = {o_we, e_we};
  assign h_data = {o_data, e_data};

  // Half 0 stores Z(2j), half 1 stores Z(2j+1) at word j of a slot
  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [W-1:0] mem [DEPTH];
    logic [W-1:0] rdq_r;

    dro_wr_seq #(.HALF(HALF), .NSLOT(NSLOT)) u_seq (
      .clk  (clk),
      .rst  (rst),
      .we   (h_we[h]),
      .slot (h_slot[h]),
      .cnt  (h_cnt[h]),
      .last (h_last[h])
    );

    always_ff @(posedge clk) begin
      if (h_we[h]) mem[{h_slot[h], h_cnt[h]}] <= h_data[h];
      rdq_r <= mem[rd_addr];
    end

    assign h_rdq[h] = rdq_r;
  end

  assign full    = done[0] & done[1];
  assign emit    = rd_act || full[rd_slot];
  assign rd_end  = emit && (rd_idx == IW'(NPT - 1));
  assign rd_addr = {rd_slot, rd_idx[IW-1:1]};

  // Slot occupancy: set when a half completes, cleared when drained
  always_ff @(posedge clk) begin
    if (rst) begin
      done <= '0;
    end else begin
      if (rd_end) begin
        done[0][rd_slot] <= 1'b0;
        done[1][rd_slot] <= 1'b0;
      end
      for (int h = 0; h < 2; h++) begin
        if (h_last[h]) done[h][h_slot[h]] <= 1'b1;
      end
    end
  end

  // Drain sequencer: one index per cycle, next slot follows at once
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_act  <= 1'b0;
      rd_slot <= '0;
      rd_idx  <= '0;
      vld1    <= 1'b0;
      idx1    <= '0;
    end else begin
      vld1 <= emit;
      if (emit) begin
        idx1 <= rd_idx;
        if (rd_end) begin
          rd_act  <= 1'b0;
          rd_idx  <= '0;
          rd_slot <= (rd_slot == SW'(NSLOT - 1)) ? '0 : rd_slot + 1'b1;
        end else begin
          rd_act <= 1'b1;
          rd_idx <= rd_idx + 1'b1;
        end
      end
    end
  end

  // Registered output: pick the half by index parity
  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_idx  <= '0;
      out_data <= '0;
    end else begin
      out_vld  <= vld1;
      out_idx  <= idx1;
      out_data <= h_rdq[idx1[0]];
    end
  end
endmodule

// File: rtl/dct_out_reorder.sv
// Merges even/odd result streams of the shared 1-D DCT engine and
// steers each pass to its own destination in natural index order.
module dct_out_reorder
  import dro_pkg::*;
#(
  parameter int W     = 12,
  parameter int NPT   = 8,
  parameter int NSLOT = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ev_vld,
  input  logic                   ev_pass,
  input  logic [W-1:0]           ev_data,
  input  logic                   od_vld,
  input  logic                   od_pass,
  input  logic [W-1:0]           od_data,
  output logic                   tm_we,
  output logic [$clog2(NPT)-1:0] tm_idx,
  output logic [W-1:0]           tm_data,
  output logic                   co_vld,
  output logic [$clog2(NPT)-1:0] co_idx,
  output logic [W-1:0]           co_data
);
  localparam int IW = $clog2(NPT);

  logic [NPASS-1:0]          b_vld;
  logic [NPASS-1:0][IW-1:0]  b_idx;
  logic [NPASS-1:0][W-1:0]   b_data;

  // The two steering selects: each stream's tag picks its bank
  for (genvar g = 0; g < NPASS; g++) begin : g_pass
    localparam logic PSEL = 1'(g);
    logic         vl;
    logic [IW-1:0] ix;
    logic [W-1:0]  dt;

    dro_bank #(.W(W), .NPT(NPT), .NSLOT(NSLOT)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .e_we     (ev_vld && (ev_pass == PSEL)),
      .e_data   (ev_data),
      .o_we     (od_vld && (od_pass == PSEL)),
      .o_data   (od_data),
      .out_vld  (vl),
      .out_idx  (ix),
      .out_data (dt)
    );

    assign b_vld[g]  = vl;
    assign b_idx[g]  = ix;
    assign b_data[g] = dt;
  end

  assign tm_we   = b_vld[PASS_ROW];
  assign tm_idx  = b_idx[PASS_ROW];
  assign tm_data = b_data[PASS_ROW];
  assign co_vld  = b_vld[PASS_COL];
  assign co_idx  = b_idx[PASS_COL];
  assign co_data = b_data[PASS_COL];
endmodule

// File: rtl/dro_chk.sv
module dro_chk #(
  parameter int NPT = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   ev_vld,
  input logic                   ev_pass,
  input logic                   od_vld,
  input logic                   od_pass,
  input logic                   tm_we,
  input logic [$clog2(NPT)-1:0] tm_idx,
  input logic                   co_vld,
  input logic [$clog2(NPT)-1:0] co_idx
);
  localparam int IW = $clog2(NPT);
  localparam logic [IW-1:0] LAST = IW'(NPT - 1);

  int unsigned in0, in1, out0, out1;

  always_ff @(posedge clk) begin
    if (rst) begin
      in0 <= 0; in1 <= 0; out0 <= 0; out1 <= 0;
    end else begin
      in0  <= in0 + 32'(ev_vld && !ev_pass) + 32'(od_vld && !od_pass);
      in1  <= in1 + 32'(ev_vld && ev_pass) + 32'(od_vld && od_pass);
      out0 <= out0 + 32'(tm_we);
      out1 <= out1 + 32'(co_vld);
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!tm_we && !co_vld)); // R1
  AST_TM_START_ZERO: assert property (@(posedge clk) disable iff (rst) $rose(tm_we) |-> (tm_idx == '0)); // R3
  AST_TM_IDX_STEP: assert property (@(posedge clk) disable iff (rst) (tm_we && $past(tm_we)) |-> (tm_idx == (($past(tm_idx) == LAST) ? '0 : $past(tm_idx) + 1'b1))); // R3
  AST_CO_IDX_STEP: assert property (@(posedge clk) disable iff (rst) (co_vld && $past(co_vld)) |-> (co_idx == (($past(co_idx) == LAST) ? '0 : $past(co_idx) + 1'b1))); // R4
  AST_NO_CROSS_PASS: assert property (@(posedge clk) disable iff (rst) (out0 <= in0) && (out1 <= in1)); // R5
  AST_TM_FULL_FIRST: assert property (@(posedge clk) disable iff (rst) (tm_we && tm_idx == '0) |-> (in0 >= out0 + NPT)); // R6
  AST_CO_FULL_FIRST: assert property (@(posedge clk) disable iff (rst) (co_vld && co_idx == '0) |-> (in1 >= out1 + NPT)); // R6
  AST_TM_NO_GAP: assert property (@(posedge clk) disable iff (rst) (tm_we && tm_idx != LAST) |=> tm_we); // R7
  AST_CO_NO_GAP: assert property (@(posedge clk) disable iff (rst) (co_vld && co_idx != LAST) |=> co_vld); // R7
endmodule

bind dct_out_reorder dro_chk #(.NPT(NPT)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ev_vld  (ev_vld),
  .ev_pass (ev_pass),
  .od_vld  (od_vld),
  .od_pass (od_pass),
  .tm_we   (tm_we),
  .tm_idx  (tm_idx),
  .co_vld  (co_vld),
  .co_idx  (co_idx)
);

// File: tb/dct_out_reorder_tb_top.sv
module dct_out_reorder_tb_top;
  localparam int W    = 12;
  localparam int NPT  = 8;
  localparam int HALF = NPT / 2;
  localparam int IW   = $clog2(NPT);

  // {pass, even offset[2], odd offset[2], seed[8]}
  localparam int NT = 10;
  localparam logic [12:0] VEC_TAB [NT] = '{
    {1'b0, 2'd0, 2'd0, 8'd3},
    {1'b1, 2'd0, 2'd1, 8'd17},
    {1'b0, 2'd0, 2'd3, 8'd40},
    {1'b0, 2'd2, 2'd0, 8'd55},
    {1'b1, 2'd1, 2'd1, 8'd99},
    {1'b1, 2'd3, 2'd0, 8'd120},
    {1'b0, 2'd1, 2'd2, 8'd200},
    {1'b1, 2'd0, 2'd0, 8'd255},
    {1'b0, 2'd3, 2'd3, 8'd7},
    {1'b1, 2'd2, 2'd3, 8'd64}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_vld = 1'b0, ev_pass = 1'b0, od_vld = 1'b0, od_pass = 1'b0;
  logic [W-1:0] ev_data = '0, od_data = '0;
  logic tm_we, co_vld;
  logic [IW-1:0] tm_idx, co_idx;
  logic [W-1:0] tm_data, co_data;

  int n_cmp = 0, n_bad = 0;
  int ti = 0, ci = 0;
  bit both_seen = 0;
  logic [W-1:0] exp0[$], exp1[$];

  always #4 clk = ~clk;

  dct_out_reorder #(.W(W), .NPT(NPT)) dut_i (
    .clk(clk), .rst(rst),
    .ev_vld(ev_vld), .ev_pass(ev_pass), .ev_data(ev_data),
    .od_vld(od_vld), .od_pass(od_pass), .od_data(od_data),
    .tm_we(tm_we), .tm_idx(tm_idx), .tm_data(tm_data),
    .co_vld(co_vld), .co_idx(co_idx), .co_data(co_data)
  );

  function automatic logic [W-1:0] val(input int s, input int k);
    return W'(s * 37 + k * 113 + k * k * 5 + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: outputs compared against per-pass expectations (R2 order)
  always @(negedge clk) begin
    if (rst) begin
      ti = 0; ci = 0;
    end else begin
      if (tm_we) begin
        if (exp0.size() == 0) chk(0, "R5 transpose port unexpected value", int'(tm_data), -1);
        else begin
          logic [W-1:0] e;
          e = exp0.pop_front();
          chk(tm_data == e && int'(tm_idx) == ti, "R3/R2 transpose data*16+idx",
              int'(tm_data) * 16 + int'(tm_idx), int'(e) * 16 + ti);
        end
        ti = (ti + 1) % NPT;
      end
      if (co_vld) begin
        if (exp1.size() == 0) chk(0, "R5 final port unexpected value", int'(co_data), -1);
        else begin
          logic [W-1:0] e;
          e = exp1.pop_front();
          chk(co_data == e && int'(co_idx) == ci, "R4/R2 final data*16+idx",
              int'(co_data) * 16 + int'(co_idx), int'(e) * 16 + ci);
        end
        ci = (ci + 1) % NPT;
      end
      if (tm_we && co_vld) both_seen = 1;
    end
  end

  task automatic send_vec(input logic p, input int eo, input int oo, input int seed);
    for (int k = 0; k < NPT; k++) begin
      if (p) exp1.push_back(val(seed, k));
      else   exp0.push_back(val(seed, k));
    end
    for (int c = 0; c < NPT; c++) begin
      @(negedge clk);
      ev_pass = p; od_pass = p;
      ev_vld  = (c >= eo && c < eo + HALF);
      od_vld  = (c >= oo && c < oo + HALF);
      ev_data = val(seed, 2 * (c - eo));
      od_data = val(seed, 2 * (c - oo) + 1);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ev_vld = 0; od_vld = 0;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (4) @(negedge clk);
    chk(!tm_we && !co_vld, "R1 outputs idle in reset", int'(tm_we) + 2 * int'(co_vld), 0);
    rst = 0;
    @(negedge clk);
    chk(!tm_we && !co_vld, "R1 outputs idle after reset", int'(tm_we) + 2 * int'(co_vld), 0);

    // Table walk: mixed passes and half offsets (R8, R9)
    for (int t = 0; t < NT; t++)
      send_vec(VEC_TAB[t][12], int'(VEC_TAB[t][11:10]), int'(VEC_TAB[t][9:8]), int'(VEC_TAB[t][7:0]));
    idle(40);
    chk(exp0.size() == 0 && exp1.size() == 0, "R8 all table vectors delivered",
        exp0.size() + exp1.size(), 0);
    chk(both_seen, "R9 both ports valid in one cycle", int'(both_seen), 1);

    // R6: latency from last accepted value
    for (int k = 0; k < NPT; k++) exp0.push_back(val(77, k));
    for (int c = 0; c < HALF; c++) begin
      @(negedge clk);
      ev_vld = 1; od_vld = 1; ev_pass = 0; od_pass = 0;
      ev_data = val(77, 2 * c); od_data = val(77, 2 * c + 1);
    end
    @(negedge clk);
    ev_vld = 0; od_vld = 0;
    chk(!tm_we, "R6 no output one edge after last value", int'(tm_we), 0);
    @(negedge clk);
    chk(!tm_we, "R6 no output at second edge boundary", int'(tm_we), 0);
    @(negedge clk);
    chk(tm_we && tm_idx == '0, "R6 index 0 valid after E+2", int'(tm_we) * 16 + int'(tm_idx), 16);
    idle(12);

    // R7: two first-pass vectors, output without gap
    begin
      int run = 0;
      fork
        begin send_vec(0, 0, 0, 150); send_vec(0, 0, 0, 151); end
        begin
          do @(negedge clk); while (!tm_we);
          while (tm_we) begin run++; @(negedge clk); end
        end
      join
      chk(run == 2 * NPT, "R7 back-to-back vectors contiguous", run, 2 * NPT);
    end
    idle(20);

    // R10: partial vector discarded by reset
    begin
      int seen = 0;
      for (int c = 0; c < HALF; c++) begin
        @(negedge clk);
        ev_vld = 1; ev_pass = 0; ev_data = val(90, 2 * c);
        od_vld = (c == 0); od_pass = 0; od_data = val(90, 1);
      end
      @(negedge clk);
      ev_vld = 0; od_vld = 0; rst = 1;
      repeat (2) @(negedge clk);
      rst = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (tm_we || co_vld) seen++;
      end
      chk(seen == 0, "R10 no output from discarded partial vector", seen, 0);
      send_vec(0, 1, 0, 33);
      send_vec(1, 0, 2, 34);
      idle(24);
      chk(exp0.size() == 0 && exp1.size() == 0, "R10 fresh vectors delivered after reset",
          exp0.size() + exp1.size(), 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule